// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the register front end of a packet-DMA disk-controller channel group. A simple memory-mapped bus reaches it with byte, halfword and word accesses. Each channel has its own 32-byte window. The window holds a control word, a status byte, a descriptor count, a next-descriptor pointer and two FIFO thresholds. The block turns those registers into control signals for the rest of the channel: a start pulse, engine reset, drive hard reset, automatic-mode enable, PIO mode and interrupt mask. It also turns the channel's event inputs into read-to-clear status and an interrupt line.

A single global lock byte, shared by all channels, must hold the key value 7 before any start request has an effect. Once the key is written, the byte is frozen until reset.

The descriptor engine, data movement and the drive interface are not part of this block. They appear only as event inputs and control outputs.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Channel n occupies byte addresses 0x80+0x20*n to 0x9F+0x20*n, for two channels, and the lock byte sits at 0xC7. `size_i` encodes the access width: 0 is a byte, 1 a halfword, 2 a word. Read data is right-aligned and appears on `rdata_o` with `rvalid_o` high in the cycle after the request. An unmapped read returns 0.
- R2: The control word is at window offset 0x0, reset value 0x0103. Its stored bits are:
  - bit 8: interrupt mask, on `irq_mask_o`
  - bit 5: engine reset, on `eng_rst_o`
  - bit 3: automatic mode, on `auto_en_o`
  - bit 2: drive hard reset, on `drv_rst_o`
  - bits 1:0: PIO mode, on `pio_mode_o`

  All other control bits read as 0.
- R3: A write that covers control byte 0 with bit 7 set gives a one-cycle `start_o` pulse in the next cycle, but only if the lock is armed and the written control value has bit 5 clear. Bit 7 always reads as 0.
- R4: The lock byte resets to 0 and is armed when it holds 7. Once armed, further writes to it are ignored.
- R5: The status byte is at window offset 0x2. The input events set these bits: bit 0 packet error, bit 1 completion, bit 4 unexpected interrupt, bit 6 drive error. Set bits accumulate until cleared.
- R6: A read that covers the status byte returns the flags held before that cycle and clears them. An event arriving in the same cycle as the read is kept for the next read.
- R7: Bus writes to the status byte have no effect.
- R8: While control bit 5 is set, status is held at 0 and events are dropped. Writing control 0x0003 leaves engine reset and automatic mode both off (plain register mode).
- R9: `irq_o` is high when bit 8 is clear and either status is nonzero or a completion event is present in that cycle.
- R10: The following registers reset to 0 and take byte-granular partial writes:
  - descriptor count, 16 bits at offset 0x4
  - next-descriptor pointer, 32 bits at offset 0xC, with bits 2:0 forced to 0
  - inbound FIFO threshold, 16 bits at offset 0x14
  - outbound FIFO threshold, 16 bits at offset 0x16
- R11: Accesses and events for one channel never change another channel's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| size_i | input | 2 | Access width code |
| wdata_i | input | 32 | Right-aligned write data |
| rdata_o | output | 32 | Right-aligned read data |
| rvalid_o | output | 1 | Read data valid |
| done_evt_i | input | NCH | Per-channel completion event |
| perr_evt_i | input | NCH | Per-channel packet error event |
| uirq_evt_i | input | NCH | Per-channel unexpected interrupt event |
| derr_evt_i | input | NCH | Per-channel drive error event |
| start_o | output | NCH | Start pulse to the descriptor engine |
| eng_rst_o | output | NCH | Engine reset level |
| drv_rst_o | output | NCH | Drive hard reset level |
| irq_mask_o | output | NCH | Interrupt mask level |
| auto_en_o | output | NCH | Automatic mode enable |
| pio_mode_o | output | 2*NCH | PIO mode per channel |
| desc_cnt_o | output | 16*NCH | Descriptor count per channel |
| next_ptr_o | output | 32*NCH | Next-descriptor pointer per channel |
| fifo_in_thr_o | output | 16*NCH | Inbound FIFO threshold per channel |
| fifo_out_thr_o | output | 16*NCH | Outbound FIFO threshold per channel |
| irq_o | output | NCH | Per-channel interrupt |

## Verification
A status read and an incoming event can fall in the same cycle. The bench provokes this by driving an event for exactly the cycle in which a status read is issued. It judges the result by two reads: the first must return only the flags held before that cycle, and the next must return the new flag alone. Engine reset is also placed against events, to show that an event arriving during reset is dropped rather than deferred.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_CNT  = 4;
  localparam int OFF_PTR  = 12;
  localparam int OFF_FIN  = 20;
  localparam int OFF_FOUT = 22;

  localparam int CB_PIO   = 0;
  localparam int CB_DRST  = 2;
  localparam int CB_AUTO  = 3;
  localparam int CB_ERST  = 5;
  localparam int CB_START = 7;
  localparam int CB_MASK  = 8;

  localparam int SB_PERR = 0;
  localparam int SB_DONE = 1;
  localparam int SB_UIRQ = 4;
  localparam int SB_DERR = 6;

  localparam logic [15:0] CTRL_RST   = 16'h0103;
  localparam logic [15:0] CTRL_WMASK = 16'h012F;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  function automatic int size_bytes(logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dma_mode_lock.sv
module dma_mode_lock #(
  parameter logic [7:0] KEY = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] lock_q_o,
  output logic       armed_o
);
  logic [7:0] lock_q;

  assign armed_o  = (lock_q == KEY);
  assign lock_q_o = lock_q;

  // frozen once the key is in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lock_q <= '0;
    else if (wr_i && !armed_o)  lock_q <= wdata_i;
  end

  p_lock_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> (armed_o && $stable(lock_q_o)));
endmodule

// File: rtl/dma_chan_win.sv
module dma_chan_win import dma_regs_pkg::*; #(
  parameter int WIN_BYTES = 32,
  parameter int PTR_ALIGN = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [$clog2(WIN_BYTES)-1:0] off_i,
  input  logic [1:0]                   size_i,
  input  logic [31:0]                  wdata_i,
  input  logic                         lock_ok_i,
  input  logic                         done_evt_i,
  input  logic                         perr_evt_i,
  input  logic                         uirq_evt_i,
  input  logic                         derr_evt_i,
  output logic [31:0]                  rdata_o,
  output logic                         start_o,
  output logic                         eng_rst_o,
  output logic                         drv_rst_o,
  output logic                         irq_mask_o,
  output logic                         auto_en_o,
  output logic [1:0]                   pio_mode_o,
  output logic [15:0]                  desc_cnt_o,
  output logic [31:0]                  next_ptr_o,
  output logic [15:0]                  fifo_in_thr_o,
  output logic [15:0]                  fifo_out_thr_o,
  output logic                         irq_o
);
  localparam int IMG_W = 8 * WIN_BYTES;
  localparam logic [31:0] PTR_KEEP = ~((32'd1 << PTR_ALIGN) - 32'd1);

  logic [15:0] ctrl_q, ctrl_nxt;
  logic [7:0]  status_q, status_d, ev;
  logic [15:0] cnt_q, cnt_nxt, fin_q, fin_nxt, fout_q, fout_nxt;
  logic [31:0] ptr_q, ptr_nxt;
  logic        start_q, start_d, rd_clr;
  int          nbytes;

  logic [WIN_BYTES-1:0] be;
  logic [7:0]           wb [WIN_BYTES];
  logic [IMG_W-1:0]     img;

  // byte lanes: window byte k takes write byte k-off
  always_comb begin
    nbytes = size_bytes(size_i);
    for (int k = 0; k < WIN_BYTES; k++) begin
      be[k] = wr_i && (k >= int'(off_i)) && (k < int'(off_i) + nbytes);
      wb[k] = 8'(wdata_i >> (8 * ((k - int'(off_i)) & 3)));
    end
  end

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (be[OFF_CTRL])     ctrl_nxt[7:0]  = wb[OFF_CTRL];
    if (be[OFF_CTRL + 1]) ctrl_nxt[15:8] = wb[OFF_CTRL + 1];
    ctrl_nxt = ctrl_nxt & CTRL_WMASK;

    cnt_nxt  = cnt_q;
    fin_nxt  = fin_q;
    fout_nxt = fout_q;
    for (int b = 0; b < 2; b++) begin
      if (be[OFF_CNT + b])  cnt_nxt[8*b +: 8]  = wb[OFF_CNT + b];
      if (be[OFF_FIN + b])  fin_nxt[8*b +: 8]  = wb[OFF_FIN + b];
      if (be[OFF_FOUT + b]) fout_nxt[8*b +: 8] = wb[OFF_FOUT + b];
    end
    ptr_nxt = ptr_q;
    for (int b = 0; b < 4; b++)
      if (be[OFF_PTR + b]) ptr_nxt[8*b +: 8] = wb[OFF_PTR + b];
    ptr_nxt = ptr_nxt & PTR_KEEP;
  end

  assign start_d = be[OFF_CTRL] && wb[OFF_CTRL][CB_START] && lock_ok_i && !ctrl_nxt[CB_ERST];

  // status: read-clear, same-cycle events survive, reset holds clear
  always_comb begin
    ev = '0;
    ev[SB_PERR] = perr_evt_i;
    ev[SB_DONE] = done_evt_i;
    ev[SB_UIRQ] = uirq_evt_i;
    ev[SB_DERR] = derr_evt_i;
    rd_clr = rd_i && (int'(off_i) <= OFF_STAT) && (int'(off_i) + nbytes > OFF_STAT);
    if (ctrl_q[CB_ERST]) status_d = '0;
    else                 status_d = (rd_clr ? 8'h00 : status_q) | ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      status_q <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      fin_q    <= '0;
      fout_q   <= '0;
      start_q  <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_nxt;
      status_q <= status_d;
      cnt_q    <= cnt_nxt;
      ptr_q    <= ptr_nxt;
      fin_q    <= fin_nxt;
      fout_q   <= fout_nxt;
      start_q  <= start_d;
    end
  end

  always_comb begin
    img = '0;
    img[8*OFF_CTRL +: 16] = ctrl_q;
    img[8*OFF_STAT +: 8]  = status_q;
    img[8*OFF_CNT  +: 16] = cnt_q;
    img[8*OFF_PTR  +: 32] = ptr_q;
    img[8*OFF_FIN  +: 16] = fin_q;
    img[8*OFF_FOUT +: 16] = fout_q;
  end

  assign rdata_o = 32'(img >> (8 * int'(off_i))) & size_mask(size_i);

  assign start_o        = start_q;
  assign eng_rst_o      = ctrl_q[CB_ERST];
  assign drv_rst_o      = ctrl_q[CB_DRST];
  assign irq_mask_o     = ctrl_q[CB_MASK];
  assign auto_en_o      = ctrl_q[CB_AUTO];
  assign pio_mode_o     = ctrl_q[CB_PIO +: 2];
  assign desc_cnt_o     = cnt_q;
  assign next_ptr_o     = ptr_q;
  assign fifo_in_thr_o  = fin_q;
  assign fifo_out_thr_o = fout_q;
  assign irq_o          = !ctrl_q[CB_MASK] && ((|status_q) || done_evt_i);

  p_start_not_in_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !eng_rst_o);
  p_event_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_evt_i && !ctrl_q[CB_ERST]) |=> status_q[SB_PERR]);
  p_status_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_clr && (ev == 8'h00) && !ctrl_q[CB_ERST]) |=> $stable(status_q));
  p_reset_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CB_ERST] |=> (status_q == 8'h00));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl import dma_regs_pkg::*; #(
  parameter int         NCH       = 2,
  parameter int         ADDR_W    = 8,
  parameter int         CH_BASE   = 'h80,
  parameter int         CH_STRIDE = 'h20,
  parameter int         LOCK_ADDR = 'hC7,
  parameter logic [7:0] LOCK_KEY  = 8'h07,
  parameter int         PTR_ALIGN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic [NCH-1:0]    done_evt_i,
  input  logic [NCH-1:0]    perr_evt_i,
  input  logic [NCH-1:0]    uirq_evt_i,
  input  logic [NCH-1:0]    derr_evt_i,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    eng_rst_o,
  output logic [NCH-1:0]    drv_rst_o,
  output logic [NCH-1:0]    irq_mask_o,
  output logic [NCH-1:0]    auto_en_o,
  output logic [2*NCH-1:0]  pio_mode_o,
  output logic [16*NCH-1:0] desc_cnt_o,
  output logic [32*NCH-1:0] next_ptr_o,
  output logic [16*NCH-1:0] fifo_in_thr_o,
  output logic [16*NCH-1:0] fifo_out_thr_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int OFF_W = $clog2(CH_STRIDE);

  logic [NCH-1:0] ch_hit;
  logic [31:0]    ch_rdata [NCH];
  logic [7:0]     lock_q;
  logic           armed, lock_hit;
  logic [31:0]    rsel, rdata_q;
  logic           rvalid_q;

  assign lock_hit = req_i && (int'(addr_i) == LOCK_ADDR);

  dma_mode_lock #(.KEY(LOCK_KEY)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (lock_hit && we_i),
    .wdata_i  (wdata_i[7:0]),
    .lock_q_o (lock_q),
    .armed_o  (armed)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int LO = CH_BASE + ch * CH_STRIDE;
    logic [OFF_W-1:0] off;

    assign ch_hit[ch] = req_i && (int'(addr_i) >= LO) && (int'(addr_i) < LO + CH_STRIDE);
    assign off        = OFF_W'(int'(addr_i) - LO);

    dma_chan_win #(.WIN_BYTES(CH_STRIDE), .PTR_ALIGN(PTR_ALIGN)) u_win (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_i           (ch_hit[ch] && we_i),
      .rd_i           (ch_hit[ch] && !we_i),
      .off_i          (off),
      .size_i         (size_i),
      .wdata_i        (wdata_i),
      .lock_ok_i      (armed),
      .done_evt_i     (done_evt_i[ch]),
      .perr_evt_i     (perr_evt_i[ch]),
      .uirq_evt_i     (uirq_evt_i[ch]),
      .derr_evt_i     (derr_evt_i[ch]),
      .rdata_o        (ch_rdata[ch]),
      .start_o        (start_o[ch]),
      .eng_rst_o      (eng_rst_o[ch]),
      .drv_rst_o      (drv_rst_o[ch]),
      .irq_mask_o     (irq_mask_o[ch]),
      .auto_en_o      (auto_en_o[ch]),
      .pio_mode_o     (pio_mode_o[2*ch +: 2]),
      .desc_cnt_o     (desc_cnt_o[16*ch +: 16]),
      .next_ptr_o     (next_ptr_o[32*ch +: 32]),
      .fifo_in_thr_o  (fifo_in_thr_o[16*ch +: 16]),
      .fifo_out_thr_o (fifo_out_thr_o[16*ch +: 16]),
      .irq_o          (irq_o[ch])
    );
  end

  always_comb begin
    rsel = lock_hit ? {24'h0, lock_q} : 32'h0;
    for (int c = 0; c < NCH; c++)
      if (ch_hit[c]) rsel = rsel | ch_rdata[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rsel;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_start_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> armed);
  p_read_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
endmodule

// File: tb/tb_dma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctrl;
  localparam int NCH = 2;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0;
  logic [7:0]        addr_i = '0;
  logic [1:0]        size_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              rvalid_o;
  logic [NCH-1:0]    done_evt_i = '0, perr_evt_i = '0, uirq_evt_i = '0, derr_evt_i = '0;
  logic [NCH-1:0]    start_o, eng_rst_o, drv_rst_o, irq_mask_o, auto_en_o, irq_o;
  logic [2*NCH-1:0]  pio_mode_o;
  logic [16*NCH-1:0] desc_cnt_o, fifo_in_thr_o, fifo_out_thr_o;
  logic [32*NCH-1:0] next_ptr_o;

  dma_chan_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  logic done_flag = 1'b0;
  logic [NCH-1:0] start_snap;

  logic [7:0] m_img [NCH][32];
  logic [7:0] m_stat [NCH];
  logic [7:0] m_lock;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(int k);
    case (k)
      0:  return 8'h2F;
      1:  return 8'h01;
      12: return 8'hF8;
      4, 5, 13, 14, 15, 20, 21, 22, 23: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int nb(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
  endfunction

  function automatic int ch_of(logic [7:0] a);
    if (a >= 8'h80 && a < 8'hC0) return (int'(a) - 'h80) / 'h20;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a, logic [1:0] sz);
    logic [31:0] r;
    int c, o;
    r = '0;
    c = ch_of(a);
    if (a == 8'hC7) r = {24'h0, m_lock};
    else if (c >= 0) begin
      o = int'(a) - 'h80 - c * 'h20;
      for (int i = 0; i < nb(sz); i++)
        if (o + i < 32) r[8*i +: 8] = (o + i == 2) ? m_stat[c] : m_img[c][o+i];
    end
    return r;
  endfunction

  task automatic apply_ev(logic [NCH-1:0] dn, logic [NCH-1:0] pe, logic [NCH-1:0] ui, logic [NCH-1:0] de);
    for (int c = 0; c < NCH; c++)
      if (m_img[c][0][5]) m_stat[c] = 8'h00;
      else m_stat[c] = m_stat[c] | {1'b0, de[c], 1'b0, ui[c], 2'b00, dn[c], pe[c]};
  endtask

  task automatic bus_write(logic [7:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    start_snap = start_o;
  endtask

  task automatic mwrite(logic [7:0] a, logic [1:0] sz, logic [31:0] d, string tag);
    int c, o;
    logic [NCH-1:0] exp_st;
    exp_st = '0;
    c = ch_of(a);
    bus_write(a, sz, d);
    if (a == 8'hC7) begin
      if (m_lock != 8'h07) m_lock = d[7:0];
    end else if (c >= 0) begin
      o = int'(a) - 'h80 - c * 'h20;
      for (int i = 0; i < nb(sz); i++)
        if (o + i < 32)
          m_img[c][o+i] = (m_img[c][o+i] & ~wmask(o + i)) | (d[8*i +: 8] & wmask(o + i));
      if (o == 0 && d[7] && m_lock == 8'h07 && !m_img[c][0][5]) exp_st[c] = 1'b1;
      if (m_img[c][0][5]) m_stat[c] = 8'h00;
    end
    chk({tag, " start"}, 32'(start_snap), 32'(exp_st));
  endtask

  task automatic mread_ev(logic [7:0] a, logic [1:0] sz, logic [NCH-1:0] dn, logic [NCH-1:0] pe,
                          logic [NCH-1:0] ui, logic [NCH-1:0] de, string tag);
    logic [31:0] exp;
    int c, o;
    exp = model_read(a, sz);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; size_i = sz;
    done_evt_i = dn; perr_evt_i = pe; uirq_evt_i = ui; derr_evt_i = de;
    @(negedge clk_i);
    req_i = 1'b0;
    done_evt_i = '0; perr_evt_i = '0; uirq_evt_i = '0; derr_evt_i = '0;
    chk(tag, rvalid_o ? rdata_o : 32'hDEAD_BEEF, exp);
    c = ch_of(a);
    if (c >= 0) begin
      o = int'(a) - 'h80 - c * 'h20;
      if (o <= 2 && o + nb(sz) > 2) m_stat[c] = 8'h00;
    end
    apply_ev(dn, pe, ui, de);
  endtask

  task automatic mread(logic [7:0] a, logic [1:0] sz, string tag);
    mread_ev(a, sz, '0, '0, '0, '0, tag);
  endtask

  task automatic mpulse(logic [NCH-1:0] dn, logic [NCH-1:0] pe, logic [NCH-1:0] ui, logic [NCH-1:0] de);
    @(negedge clk_i);
    done_evt_i = dn; perr_evt_i = pe; uirq_evt_i = ui; derr_evt_i = de;
    @(negedge clk_i);
    done_evt_i = '0; perr_evt_i = '0; uirq_evt_i = '0; derr_evt_i = '0;
    apply_ev(dn, pe, ui, de);
  endtask

  task automatic chk_outs(int c, string tag);
    chk({tag, " ctrl outs"},
        32'({irq_mask_o[c], eng_rst_o[c], auto_en_o[c], drv_rst_o[c], pio_mode_o[2*c +: 2]}),
        32'({m_img[c][1][0], m_img[c][0][5], m_img[c][0][3], m_img[c][0][2], m_img[c][0][1:0]}));
    chk({tag, " cnt/thr"}, {desc_cnt_o[16*c +: 16], fifo_in_thr_o[16*c +: 16]},
        {m_img[c][5], m_img[c][4], m_img[c][21], m_img[c][20]});
    chk({tag, " ptr"}, next_ptr_o[32*c +: 32], {m_img[c][15], m_img[c][14], m_img[c][13], m_img[c][12]});
    chk({tag, " othr/irq"}, 32'({fifo_out_thr_o[16*c +: 16], irq_o[c]}),
        32'({m_img[c][23], m_img[c][22], !m_img[c][1][0] && (m_stat[c] != 8'h00)}));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 32; k++) m_img[c][k] = 8'h00;
      m_img[c][0] = 8'h03;
      m_img[c][1] = 8'h01;
      m_stat[c]   = 8'h00;
    end
    m_lock = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state
    chk("R2 reset outs", 32'({start_o, irq_o}), 32'h0);
    chk_outs(0, "R2 reset ch0");
    mread(8'h80, 2'd1, "R2 ctrl reset value");
    mread(8'h82, 2'd0, "R5 status reset");
    mread(8'hC7, 2'd0, "R4 lock reset");
    mread(8'h40, 2'd2, "R1 unmapped low");
    mread(8'hC0, 2'd2, "R1 unmapped high");

    // start without lock
    mwrite(8'h80, 2'd1, 32'h0088, "R3 start unlocked");
    mwrite(8'hC7, 2'd0, 32'h05, "R4 lock wrong key");
    mread(8'hC7, 2'd0, "R4 lock readback");
    mwrite(8'h80, 2'd1, 32'h0088, "R4 start with wrong key");
    mwrite(8'hC7, 2'd0, 32'h07, "R4 lock arm");
    mwrite(8'hC7, 2'd0, 32'h00, "R4 lock frozen write");
    mread(8'hC7, 2'd0, "R4 lock stays armed");

    // start armed
    mwrite(8'h80, 2'd1, 32'h0088, "R3 start armed");
    @(negedge clk_i);
    chk("R3 start single cycle", 32'(start_o), 32'h0);
    mread(8'h80, 2'd1, "R3 start bit reads zero");
    mwrite(8'hA0, 2'd0, 32'h88, "R11 start ch1 only");
    mwrite(8'h80, 2'd0, 32'hA3, "R3 start blocked by engine reset");
    chk_outs(0, "R8 reset asserted");

    // engine reset drops events
    mpulse(2'b01, 2'b01, 2'b00, 2'b00);
    mread(8'h82, 2'd0, "R8 status held clear in reset");
    mwrite(8'h80, 2'd1, 32'h0003, "R8 register mode");
    chk_outs(0, "R8 register mode");

    // accumulate and clear
    mpulse(2'b00, 2'b01, 2'b00, 2'b00);
    mpulse(2'b00, 2'b00, 2'b00, 2'b01);
    mread(8'h82, 2'd0, "R5 flags accumulate");
    mread(8'h82, 2'd0, "R6 read clears");

    // read and event in the same cycle
    mpulse(2'b00, 2'b01, 2'b00, 2'b00);
    mread_ev(8'h82, 2'd0, 2'b00, 2'b00, 2'b01, 2'b00, "R6 same-cycle read returns old");
    mread(8'h82, 2'd0, "R6 same-cycle event kept");
    mread_ev(8'h80, 2'd2, 2'b00, 2'b01, 2'b00, 2'b00, "R6 word read covering status");
    mread(8'h80, 2'd2, "R6 word read after clear");
    mread(8'h82, 2'd0, "R6 status empty");

    // status not writable
    mwrite(8'h82, 2'd0, 32'hFF, "R7 status write");
    mread(8'h82, 2'd0, "R7 status write ignored");
    mwrite(8'h80, 2'd2, 32'h00FF_0003, "R7 word write over status");
    mread(8'h80, 2'd2, "R7 word readback");

    // interrupt
    mwrite(8'h80, 2'd1, 32'h0103, "R9 mask on");
    mpulse(2'b00, 2'b00, 2'b00, 2'b01);
    chk("R9 masked irq", 32'(irq_o), 32'h0);
    mwrite(8'h80, 2'd1, 32'h0003, "R9 mask off");
    chk("R9 irq from status", 32'(irq_o), 32'h1);
    mread(8'h82, 2'd0, "R9 clear status");
    chk("R9 irq after clear", 32'(irq_o), 32'h0);
    @(negedge clk_i);
    done_evt_i = 2'b01;
    #1 chk("R9 irq from live completion", 32'(irq_o), 32'h1);
    @(negedge clk_i);
    done_evt_i = 2'b00;
    apply_ev(2'b01, 2'b00, 2'b00, 2'b00);
    mread(8'h82, 2'd0, "R5 completion flag");

    // pointer and partial writes
    mwrite(8'hAC, 2'd2, 32'hFFFF_FFFF, "R10 ptr word");
    mread(8'hAC, 2'd2, "R10 ptr low bits zero");
    mwrite(8'hAD, 2'd0, 32'h12, "R10 ptr byte");
    mread(8'hAC, 2'd2, "R10 ptr partial");
    mwrite(8'hA4, 2'd1, 32'hBEEF, "R11 cnt ch1");
    mwrite(8'hB5, 2'd0, 32'h5A, "R10 in thr high byte");
    mread(8'hB4, 2'd2, "R10 thresholds word");
    mread(8'h84, 2'd1, "R11 ch0 cnt untouched");
    chk_outs(1, "R10 ch1 outs");
    chk_outs(0, "R11 ch0 outs");
    mpulse(2'b10, 2'b10, 2'b00, 2'b00);
    mread(8'h82, 2'd0, "R11 ch0 status untouched");
    mread(8'hA2, 2'd0, "R11 ch1 status");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int c, r, w, nbt, off;
      logic [1:0] sz;
      logic [7:0] a;
      int offs [5] = '{0, 4, 12, 20, 22};
      int wid  [5] = '{2, 2, 4, 2, 2};
      c   = int'($urandom % NCH);
      r   = int'($urandom % 5);
      w   = wid[r];
      sz  = 2'($urandom % ((w == 4) ? 3 : 2));
      nbt = nb(sz);
      off = offs[r] + int'($urandom % (w / nbt)) * nbt;
      a   = 8'('h80 + c * 'h20 + off);
      case ($urandom % 4)
        0, 1: mwrite(a, sz, $urandom, "R10 random write");
        2: begin
          mread(a, sz, "R10 random readback");
          chk_outs(c, "R2 random outs");
        end
        default: begin
          logic [NCH-1:0] dn, pe, ui, de;
          dn = NCH'($urandom); pe = NCH'($urandom); ui = NCH'($urandom); de = NCH'($urandom);
          if ($urandom % 2) mpulse(dn, pe, ui, de);
          mread_ev(8'(8'h82 + c * 'h20), 2'd0, dn & NCH'($urandom), pe, ui & NCH'($urandom), de,
                   "R6 random status");
        end
      endcase
    end

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule